// File: doc/BRIEF.md
# Two-Way Write-Back Data Cache

This block is a small data cache between a 16-bit processor and a 4K-word main memory that is addressed by word. It holds 64 lines organised as 32 sets of two ways. Each line stores a four-word block along with a tag, a valid flag and a modified flag. Each set also keeps one bit that marks its least recently used way. Writes are write-back with write-allocate: a write hit changes only the cached word. Main memory is updated only when a modified line is evicted.

The processor raises `cpu_req` together with the address, the direction and the write data. It holds them until `cpu_ready` pulses for one cycle. For a read, the word is on `cpu_rdata` in that same cycle. The memory side is a single-word port: `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` stay steady until `mem_ready` accepts the beat. On a read beat, `mem_rdata` is taken in the cycle of `mem_ready`.

The controller has five states:
- **IDLE** goes to **LOOKUP** when a request is seen, and latches it.
- **LOOKUP** goes to **COMPLETE** on a hit. On a miss it goes to **WRITEBACK** if the victim is valid and modified, and to **REFILL** otherwise.
- **WRITEBACK** issues four word writes and then goes to **REFILL**.
- **REFILL** issues four word reads, installs the line, and returns to **LOOKUP**. That second lookup now hits.
- **COMPLETE** raises `cpu_ready` and goes back to **IDLE**.

Top module: `twoway_wb_cache`

## Requirements
- R1: After reset every line is invalid and `cpu_ready` and `mem_req` are low. The first access to any block after reset misses and fetches it from memory.
- R2: A word address splits into the tag in bits [11:7], the set index in bits [6:2] and the word offset in bits [1:0].
- R3: A read that hits returns the addressed word, with no memory traffic.
- R4: A read miss issues four memory reads to the aligned block, at offsets 0, 1, 2 and 3 in that order. The processor gets the requested word only after the fourth read. While a beat waits for `mem_ready`, its request, direction and address stay steady.
- R5: A write that hits changes only the addressed word, marks the line modified and makes no memory traffic.
- R6: A write miss first loads the whole block from memory and then writes the new word into it. The line ends up modified.
- R7: On a miss, an invalid way is filled first, with way 0 before way 1. Otherwise the least recently used way of the set is replaced. Every hit and every fill makes the way it used the most recent.
- R8: A modified victim is written back before the refill: four writes to its own block at offsets 0 to 3, carrying the latest data. A clean or invalid victim causes no memory write.
- R9: `cpu_ready` is a single-cycle pulse for each request. `mem_we` is only ever high together with `mem_req`.
- R10: While no request is pending, the memory port stays idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor request, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 12 | Word address |
| cpu_wdata | input | 16 | Write data |
| cpu_ready | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | 16 | Read data, valid with `cpu_ready` |
| mem_req | output | 1 | Memory beat request |
| mem_we | output | 1 | 1 = memory write beat |
| mem_addr | output | 12 | Memory word address |
| mem_wdata | output | 16 | Write-back data |
| mem_rdata | input | 16 | Memory read data |
| mem_ready | input | 1 | Memory accepts or returns the current beat |

## Verification
Some properties are checked on every cycle by the assertions:
- the single-cycle `cpu_ready` pulse and `mem_we` never appearing without `mem_req`;
- the memory beat holding steady while `mem_ready` is low;
- the WRITEBACK state being entered only for a valid, modified victim;
- each touch pointing the set's LRU bit at the other way;
- fills leaving the line valid and clean.

Other behaviour can only be shown by the bench's scenarios, which compare against a reference memory and a model of the tags:
- that reads return the latest data;
- that misses produce exactly four beats at the right block addresses;
- which way is chosen as the victim;
- that write-back carries the most recent words;
- that a reset discards cached lines.

// File: rtl/cache_pkg.sv
package cache_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOOKUP,
        ST_WRITEBACK,
        ST_REFILL,
        ST_COMPLETE
    } cache_state_t;

endpackage

// File: rtl/cache_tag_store.sv
module cache_tag_store #(
    parameter int SETS  = 32,
    parameter int TAG_W = 5,
    localparam int IDX_W = $clog2(SETS)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [IDX_W-1:0]        set_i,
    input  logic                    touch_en_i,
    input  logic                    touch_way_i,
    input  logic                    dirty_en_i,
    input  logic                    dirty_way_i,
    input  logic                    fill_en_i,
    input  logic                    fill_way_i,
    input  logic [TAG_W-1:0]        fill_tag_i,
    output logic [1:0]              valid_o,
    output logic [1:0]              dirty_o,
    output logic [1:0][TAG_W-1:0]   tag_o,
    output logic                    lru_o
);

    logic lru_q [SETS];

    for (genvar w = 0; w < 2; w++) begin : g_way
        logic             vld_q [SETS];
        logic             drt_q [SETS];
        logic [TAG_W-1:0] tag_q [SETS];

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                for (int i = 0; i < SETS; i++) begin
                    vld_q[i] <= 1'b0;
                    drt_q[i] <= 1'b0;
                end
            end else if (fill_en_i && fill_way_i == 1'(w)) begin
                vld_q[set_i] <= 1'b1;
                drt_q[set_i] <= 1'b0;
            end else if (dirty_en_i && dirty_way_i == 1'(w)) begin
                drt_q[set_i] <= 1'b1;
            end
        end

        always_ff @(posedge clk) begin
            if (fill_en_i && fill_way_i == 1'(w))
                tag_q[set_i] <= fill_tag_i;
        end

        assign valid_o[w] = vld_q[set_i];
        assign dirty_o[w] = drt_q[set_i];
        assign tag_o[w]   = tag_q[set_i];

        // R6 R8: a fill leaves the line valid and clean
        a_r8_fill_clean: assert property (@(posedge clk) disable iff (!rst_n)
            (fill_en_i && fill_way_i == 1'(w)) |=> (vld_q[$past(set_i)] && !drt_q[$past(set_i)]));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < SETS; i++) lru_q[i] <= 1'b0;
        end else if (touch_en_i) begin
            lru_q[set_i] <= ~touch_way_i;
        end
    end

    assign lru_o = lru_q[set_i];

    // R7: after a touch the LRU bit names the other way
    a_r7_lru_other: assert property (@(posedge clk) disable iff (!rst_n)
        touch_en_i |=> (lru_q[$past(set_i)] != $past(touch_way_i)));

endmodule

// File: rtl/cache_data_store.sv
module cache_data_store #(
    parameter int SETS   = 32,
    parameter int WORDS  = 4,
    parameter int DATA_W = 16,
    localparam int IDX_W = $clog2(SETS),
    localparam int OFF_W = $clog2(WORDS)
) (
    input  logic                    clk,
    input  logic [IDX_W-1:0]        set_i,
    input  logic [OFF_W-1:0]        rd_off_i,
    input  logic                    wr_en_i,
    input  logic                    wr_way_i,
    input  logic [OFF_W-1:0]        wr_off_i,
    input  logic [DATA_W-1:0]       wr_data_i,
    output logic [1:0][DATA_W-1:0]  rd_data_o
);

    for (genvar w = 0; w < 2; w++) begin : g_way
        logic [DATA_W-1:0] arr_q [SETS][WORDS];

        always_ff @(posedge clk) begin
            if (wr_en_i && wr_way_i == 1'(w))
                arr_q[set_i][wr_off_i] <= wr_data_i;
        end

        assign rd_data_o[w] = arr_q[set_i][rd_off_i];
    end

endmodule

// File: rtl/cache_ctrl.sv
module cache_ctrl
    import cache_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 16,
    parameter int SETS   = 32,
    parameter int WORDS  = 4,
    localparam int IDX_W = $clog2(SETS),
    localparam int OFF_W = $clog2(WORDS),
    localparam int TAG_W = ADDR_W - IDX_W - OFF_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cpu_req,
    input  logic                    cpu_we,
    input  logic [ADDR_W-1:0]       cpu_addr,
    input  logic [DATA_W-1:0]       cpu_wdata,
    output logic                    cpu_ready,
    output logic [DATA_W-1:0]       cpu_rdata,
    output logic                    mem_req,
    output logic                    mem_we,
    output logic [ADDR_W-1:0]       mem_addr,
    output logic [DATA_W-1:0]       mem_wdata,
    input  logic [DATA_W-1:0]       mem_rdata,
    input  logic                    mem_ready,
    output logic [IDX_W-1:0]        set_o,
    input  logic [1:0]              valid_i,
    input  logic [1:0]              dirty_i,
    input  logic [1:0][TAG_W-1:0]   tag_i,
    input  logic                    lru_i,
    output logic                    touch_en_o,
    output logic                    touch_way_o,
    output logic                    dirty_en_o,
    output logic                    dirty_way_o,
    output logic                    fill_en_o,
    output logic                    fill_way_o,
    output logic [TAG_W-1:0]        fill_tag_o,
    output logic [OFF_W-1:0]        rd_off_o,
    output logic                    wr_en_o,
    output logic                    wr_way_o,
    output logic [OFF_W-1:0]        wr_off_o,
    output logic [DATA_W-1:0]       wr_data_o,
    input  logic [1:0][DATA_W-1:0]  rd_data_i
);

    localparam logic [OFF_W-1:0] LAST = OFF_W'(WORDS - 1);

    cache_state_t      state_q, state_d;
    logic [ADDR_W-1:0] addr_q;
    logic              we_q;
    logic [DATA_W-1:0] wdata_q, rdata_q;
    logic [OFF_W-1:0]  cnt_q;
    logic              vict_q;

    logic [TAG_W-1:0]  tag_a;
    logic [IDX_W-1:0]  idx_a;
    logic [OFF_W-1:0]  off_a;
    logic              hit0, hit1, hit, hit_way, victim;

    assign tag_a   = addr_q[ADDR_W-1 -: TAG_W];
    assign idx_a   = addr_q[OFF_W +: IDX_W];
    assign off_a   = addr_q[OFF_W-1:0];
    assign hit0    = valid_i[0] && (tag_i[0] == tag_a);
    assign hit1    = valid_i[1] && (tag_i[1] == tag_a);
    assign hit     = hit0 || hit1;
    assign hit_way = hit1;
    assign victim  = !valid_i[0] ? 1'b0 : (!valid_i[1] ? 1'b1 : lru_i);

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      if (cpu_req) state_d = ST_LOOKUP;
            ST_LOOKUP: begin
                if (hit)                                  state_d = ST_COMPLETE;
                else if (valid_i[victim] && dirty_i[victim]) state_d = ST_WRITEBACK;
                else                                      state_d = ST_REFILL;
            end
            ST_WRITEBACK: if (mem_ready && cnt_q == LAST) state_d = ST_REFILL;
            ST_REFILL:    if (mem_ready && cnt_q == LAST) state_d = ST_LOOKUP;
            ST_COMPLETE:  state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // request and beat bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            we_q    <= 1'b0;
            wdata_q <= '0;
            rdata_q <= '0;
            cnt_q   <= '0;
            vict_q  <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (cpu_req) begin
                    addr_q  <= cpu_addr;
                    we_q    <= cpu_we;
                    wdata_q <= cpu_wdata;
                    cnt_q   <= '0;
                end
                ST_LOOKUP: begin
                    if (hit) rdata_q <= we_q ? wdata_q : rd_data_i[hit_way];
                    else begin
                        vict_q <= victim;
                        cnt_q  <= '0;
                    end
                end
                ST_WRITEBACK, ST_REFILL: if (mem_ready) cnt_q <= cnt_q + 1'b1;
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        cpu_ready   = (state_q == ST_COMPLETE);
        cpu_rdata   = rdata_q;
        mem_req     = (state_q == ST_WRITEBACK) || (state_q == ST_REFILL);
        mem_we      = (state_q == ST_WRITEBACK);
        mem_addr    = (state_q == ST_WRITEBACK) ? {tag_i[vict_q], idx_a, cnt_q}
                                                : {tag_a, idx_a, cnt_q};
        mem_wdata   = rd_data_i[vict_q];
        set_o       = idx_a;
        touch_en_o  = (state_q == ST_LOOKUP) && hit;
        touch_way_o = hit_way;
        dirty_en_o  = (state_q == ST_LOOKUP) && hit && we_q;
        dirty_way_o = hit_way;
        fill_en_o   = (state_q == ST_REFILL) && mem_ready && (cnt_q == LAST);
        fill_way_o  = vict_q;
        fill_tag_o  = tag_a;
        rd_off_o    = (state_q == ST_WRITEBACK) ? cnt_q : off_a;
        wr_en_o     = ((state_q == ST_LOOKUP) && hit && we_q) ||
                      ((state_q == ST_REFILL) && mem_ready);
        wr_way_o    = (state_q == ST_REFILL) ? vict_q : hit_way;
        wr_off_o    = (state_q == ST_REFILL) ? cnt_q : off_a;
        wr_data_o   = (state_q == ST_REFILL) ? mem_rdata : wdata_q;
    end

    a_r9_ready_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |=> !cpu_ready);

    a_r9_we_with_req: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> mem_req);

    a_r4_beat_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    a_r8_wb_only_dirty: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WRITEBACK) |-> (valid_i[vict_q] && dirty_i[vict_q]));

endmodule

// File: rtl/twoway_wb_cache.sv
module twoway_wb_cache #(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 16,
    parameter int LINES  = 64,
    parameter int WORDS  = 4,
    localparam int SETS  = LINES / 2,
    localparam int IDX_W = $clog2(SETS),
    localparam int OFF_W = $clog2(WORDS),
    localparam int TAG_W = ADDR_W - IDX_W - OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_ready,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ready
);

    logic [IDX_W-1:0]             set_w;
    logic [1:0]                   valid_w, dirty_w;
    logic [1:0][TAG_W-1:0]        tag_w;
    logic                         lru_w;
    logic                         touch_en, touch_way, dirty_en, dirty_way;
    logic                         fill_en, fill_way;
    logic [TAG_W-1:0]             fill_tag;
    logic [OFF_W-1:0]             rd_off, wr_off;
    logic                         wr_en, wr_way;
    logic [DATA_W-1:0]            wr_data;
    logic [1:0][DATA_W-1:0]       rd_data;

    cache_ctrl #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SETS(SETS), .WORDS(WORDS)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ready(mem_ready),
        .set_o(set_w), .valid_i(valid_w), .dirty_i(dirty_w), .tag_i(tag_w), .lru_i(lru_w),
        .touch_en_o(touch_en), .touch_way_o(touch_way),
        .dirty_en_o(dirty_en), .dirty_way_o(dirty_way),
        .fill_en_o(fill_en), .fill_way_o(fill_way), .fill_tag_o(fill_tag),
        .rd_off_o(rd_off), .wr_en_o(wr_en), .wr_way_o(wr_way), .wr_off_o(wr_off),
        .wr_data_o(wr_data), .rd_data_i(rd_data)
    );

    cache_tag_store #(.SETS(SETS), .TAG_W(TAG_W)) u_tags (
        .clk(clk), .rst_n(rst_n), .set_i(set_w),
        .touch_en_i(touch_en), .touch_way_i(touch_way),
        .dirty_en_i(dirty_en), .dirty_way_i(dirty_way),
        .fill_en_i(fill_en), .fill_way_i(fill_way), .fill_tag_i(fill_tag),
        .valid_o(valid_w), .dirty_o(dirty_w), .tag_o(tag_w), .lru_o(lru_w)
    );

    cache_data_store #(.SETS(SETS), .WORDS(WORDS), .DATA_W(DATA_W)) u_data (
        .clk(clk), .set_i(set_w), .rd_off_i(rd_off),
        .wr_en_i(wr_en), .wr_way_i(wr_way), .wr_off_i(wr_off), .wr_data_i(wr_data),
        .rd_data_o(rd_data)
    );

endmodule

// File: tb/twoway_wb_cache_bench.sv
module twoway_wb_cache_bench;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cpu_req, cpu_we, cpu_ready;
    logic [11:0] cpu_addr, mem_addr;
    logic [15:0] cpu_wdata, cpu_rdata, mem_wdata, mem_rdata;
    logic        mem_req, mem_we, mem_ready;

    always #(CLK_PERIOD/2) clk = ~clk;

    twoway_wb_cache u_twoway_wb_cache (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ready(mem_ready)
    );

    int tests = 0, fails = 0;
    bit done = 0;

    logic [15:0] bmem [4096];
    logic [15:0] refm [4096];
    int          wr_n, rd_n;
    logic [11:0] wr_log [4];
    logic [11:0] rd_log [4];

    // bench model of line state
    bit       mv [2][32];
    bit       md [2][32];
    bit [4:0] mt [2][32];
    bit       ml [32];

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: %s actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [11:0] blk_addr(input bit [4:0] t, input bit [4:0] s, input int o);
        return {t, s, 2'(o)};
    endfunction

    assign mem_rdata = bmem[mem_addr];

    always @(negedge clk) mem_ready = ($urandom_range(3) != 0);

    // memory model and traffic monitor
    always @(posedge clk) begin
        if (rst_n && mem_req && mem_ready) begin
            if (mem_we) begin
                chk(mem_wdata == refm[mem_addr], "R8", "writeback data", mem_wdata, refm[mem_addr]);
                bmem[mem_addr] = mem_wdata;
                if (wr_n < 4) wr_log[wr_n] = mem_addr;
                wr_n++;
            end else begin
                if (rd_n < 4) rd_log[rd_n] = mem_addr;
                rd_n++;
            end
        end
    end

    task automatic model_reset();
        for (int w = 0; w < 2; w++)
            for (int s = 0; s < 32; s++) begin mv[w][s] = 0; md[w][s] = 0; end
        for (int s = 0; s < 32; s++) ml[s] = 0;
        for (int i = 0; i < 4096; i++) refm[i] = bmem[i];
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0; cpu_req = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        model_reset();
    endtask

    // one processor access, checked against the model; returns whether it hit
    task automatic access(input bit we, input logic [11:0] a, input logic [15:0] d,
                          output bit was_hit, output bit was_wb);
        bit [4:0] t = a[11:7];
        bit [4:0] s = a[6:2];
        bit       hit = 0, way = 0, wb;
        bit [4:0] wbtag;
        int       cyc = 0;
        string    rq;
        for (int w = 0; w < 2; w++)
            if (!hit && mv[w][s] && mt[w][s] == t) begin hit = 1; way = 1'(w); end
        if (!hit) way = !mv[0][s] ? 1'b0 : (!mv[1][s] ? 1'b1 : ml[s]);
        wb    = !hit && mv[way][s] && md[way][s];
        wbtag = mt[way][s];

        @(negedge clk);
        wr_n = 0; rd_n = 0;
        cpu_req = 1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
        do begin
            @(posedge clk); #1; cyc++;
        end while (!cpu_ready && cyc < 200);
        cpu_req = 0;
        chk(cpu_ready, "R9", "ready seen", cyc, 0);

        if (!we) begin
            rq = hit ? "R3" : "R4";
            chk(cpu_rdata == refm[a], rq, "read data", cpu_rdata, refm[a]);
        end
        rq = hit ? (we ? "R5" : "R3") : (we ? "R6" : "R4");
        chk(rd_n == (hit ? 0 : 4), rq, "memory reads", rd_n, hit ? 0 : 4);
        if (!hit)
            for (int i = 0; i < 4; i++)
                chk(rd_log[i] == blk_addr(t, s, i), "R2", "refill addr",
                    rd_log[i], blk_addr(t, s, i));
        chk(wr_n == (wb ? 4 : 0), "R8", "memory writes", wr_n, wb ? 4 : 0);
        if (wb)
            for (int i = 0; i < 4; i++)
                chk(wr_log[i] == blk_addr(wbtag, s, i), "R8", "writeback addr",
                    wr_log[i], blk_addr(wbtag, s, i));

        @(posedge clk); #1;
        chk(!cpu_ready, "R9", "ready pulse width", cpu_ready, 0);

        if (!hit) begin mv[way][s] = 1; md[way][s] = 0; mt[way][s] = t; end
        ml[s] = ~way;
        if (we) begin md[way][s] = 1; refm[a] = d; end
        was_hit = hit;
        was_wb  = wb;
    endtask

    task automatic rd(input logic [11:0] a, output bit h);
        bit w;
        access(0, a, 16'h0, h, w);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        bit h, w, any_req;
        void'($urandom(32'd1234));
        for (int i = 0; i < 4096; i++) bmem[i] = 16'($urandom);
        cpu_req = 0; cpu_we = 0; cpu_addr = 0; cpu_wdata = 0; rst_n = 0;
        do_reset();

        // R1 R10: quiet after reset
        any_req = 0;
        repeat (5) begin @(posedge clk); #1; any_req |= mem_req; end
        chk(!cpu_ready, "R1", "ready after reset", cpu_ready, 0);
        chk(!any_req, "R10", "idle memory port", any_req, 0);

        // R1 R4: cold miss, then R3 hit
        rd(12'h013, h); chk(!h, "R1", "cold access misses", h, 0);
        rd(12'h012, h); chk(h, "R3", "same block hits", h, 1);

        // R5: write hit keeps neighbour words
        access(1, 12'h011, 16'hBEEF, h, w); chk(h, "R5", "write hit", h, 1);
        rd(12'h011, h); rd(12'h010, h);

        // R6: write miss allocates
        access(1, 12'h244, 16'h1234, h, w); chk(!h, "R6", "write miss", h, 0);
        rd(12'h245, h); chk(h, "R6", "allocated block hits", h, 1);

        // R7: invalid-first then LRU choice in set 3
        rd(12'h00C, h); rd(12'h08C, h);   // tags 0 and 1 fill ways 0 and 1
        rd(12'h00D, h); chk(h, "R7", "tag0 still held", h, 1);
        rd(12'h10C, h); chk(!h, "R7", "tag2 misses", h, 0);
        rd(12'h00C, h); chk(h, "R7", "recent way kept", h, 1);
        rd(12'h08C, h); chk(!h, "R7", "LRU way evicted", h, 0);

        // R8: dirty victim written back, clean victim not
        access(1, 12'h016, 16'hCAFE, h, w);   // set 5 tag 0
        rd(12'h094, h); rd(12'h114, h);
        rd(12'h016, h); chk(!h, "R8", "dirty line was evicted", h, 0);

        // random mix with conflicts
        for (int n = 0; n < 2000; n++) begin
            logic [11:0] a;
            a = {3'($urandom_range(7)) , 2'b0, 3'($urandom_range(3)), 2'($urandom_range(3)), 2'($urandom)};
            a[11:7] = 5'($urandom_range(5));
            access(1'($urandom_range(1)), a, 16'($urandom), h, w);
        end

        // R1: reset discards cached lines
        do_reset();
        rd(12'h013, h); chk(!h, "R1", "miss after reset", h, 0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule